// File: doc/BRIEF.md
# Four-Wide Register Rename Map

This block keeps the mapping from architectural register numbers to physical register tags and renames a group of up to four micro-operations in each clock cycle. For every source operand in the group it returns the physical tag that will carry the value. For every micro-operation that writes a destination it hands out a fresh physical tag, taken from a set of free tags supplied by the caller, and records that tag as the new mapping.

Dependencies inside one group are resolved in the same cycle. A later slot sees the tags that earlier slots in its own group have just allocated, and the stored map ends up holding the youngest writer of each register. The same register may be written by all four slots at once. For each writer the block also reports the tag it displaces, so that the caller can return that tag to the free pool when the writer retires. All results are registered and appear one cycle after the group is presented. A stall input holds the map unchanged. The free-tag pool, checkpoints and recovery after a misprediction are handled outside the block.

Top module: `rename_map4`

## Requirements
- R1: Up to SLOTS (default 4) groups of slot inputs are accepted per cycle. On the clock edge after a cycle with stall low, `out_vld` equals the `in_vld` of that cycle and `out_wr` equals `in_vld & in_wr`.
- R2: Synchronous active-high reset sets every map entry to the identity mapping (architectural register i maps to physical tag i) and clears `out_vld`, `out_wr` and `out_alloc`.
- R3: When no earlier slot in the group writes it, a source operand returns the tag held in the map for its architectural register. Slot k, source s uses bits [(k*NSRC+s)*AW +: AW] of `in_src` and of `out_src_tag` (width PW).
- R4: Writing slots take free tags in slot order with no gaps. The n-th writing slot (counting from 0, lowest slot first) receives lane n of `free_tag` (bits [n*PW +: PW]) as its new tag. `out_alloc` reports the number of tags taken.
- R5: A source in slot k that matches the destination of a valid writing slot j<k receives slot j's new tag, and the nearest such slot wins. A slot's own destination never forwards to its own sources.
- R6: For each writing slot, `out_old_tag` is the mapping the destination had just before that slot. That is the new tag of the nearest earlier writer of the same register in the group, or the stored map value if there is none.
- R7: When several slots write the same register, the map afterwards holds the tag of the highest-numbered of them. This still holds when all four slots write one register.
- R8: A slot with `in_vld` low or `in_wr` low takes no free tag and leaves the map unchanged. Its `out_new_tag` and `out_old_tag` are zero.
- R9: While `stall` is high the map is not updated. On the following edge `out_vld`, `out_wr` and `out_alloc` are zero.
- R10: Map updates from one group are visible to the sources of the group presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Blocks all map updates and output validity |
| in_vld | input | SLOTS | Slot holds a micro-operation |
| in_wr | input | SLOTS | Slot writes a destination register |
| in_dst | input | SLOTS*AW | Destination architectural register per slot |
| in_src | input | SLOTS*NSRC*AW | Source architectural registers, slot-major |
| free_tag | input | SLOTS*PW | Free physical tags, taken from lane 0 upward |
| out_vld | output | SLOTS | Registered slot valid |
| out_wr | output | SLOTS | Registered slot writes a destination |
| out_src_tag | output | SLOTS*NSRC*PW | Physical tag for each source |
| out_new_tag | output | SLOTS*PW | Tag allocated to each writing slot |
| out_old_tag | output | SLOTS*PW | Displaced mapping for each writing slot |
| out_alloc | output | $clog2(SLOTS+1) | Number of free tags taken |

## Verification
The bench builds the block with its defaults: four slots, two sources per slot, 16 architectural and 64 physical registers. With only 16 architectural registers, both the directed groups and a long pseudo-random run often repeat a destination inside one group. This exercises same-register chains of length two to four, nearest-writer forwarding and last-writer map updates. Since every map entry can be read back through ordinary source lookups in a few groups, the identity reset, stalls that must leave the map untouched and back-to-back visibility are all checked from the ports.

// File: rtl/rat_pkg.sv
package rat_pkg;
  localparam int RAT_SLOTS = 4;
  localparam int RAT_AREGS = 16;
  localparam int RAT_PREGS = 64;
  localparam int RAT_NSRC  = 2;
endpackage

// File: rtl/rat_alloc.sv
// Hands out free tags to writing slots in slot order without gaps.
module rat_alloc #(
  parameter int SLOTS = 4,
  parameter int PW    = 6,
  localparam int CW   = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0]    wr_eff,
  input  logic [SLOTS*PW-1:0] free_tag,
  output logic [SLOTS*PW-1:0] new_tag,
  output logic [CW-1:0]       cnt
);
  always_comb begin
    int n;
    n = 0;
    new_tag = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (wr_eff[k]) begin
        new_tag[k*PW +: PW] = free_tag[n*PW +: PW];
        n = n + 1;
      end
    end
    cnt = CW'(n);
  end
endmodule

// File: rtl/rat_map.sv
// Architectural-to-physical map storage with combinational read ports.
module rat_map #(
  parameter int SLOTS = 4,
  parameter int NSRC  = 2,
  parameter int AREGS = 16,
  parameter int PREGS = 64,
  localparam int AW   = $clog2(AREGS),
  localparam int PW   = $clog2(PREGS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [SLOTS-1:0]         wr_eff,
  input  logic [SLOTS*AW-1:0]      dst,
  input  logic [SLOTS*PW-1:0]      new_tag,
  input  logic [SLOTS*NSRC*AW-1:0] src,
  output logic [SLOTS*NSRC*PW-1:0] rd_src,
  output logic [SLOTS*PW-1:0]      rd_dst
);
  logic [PW-1:0] tbl [AREGS];

  // Ascending slot order: the highest writer of a register lands last.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < AREGS; i++) tbl[i] <= PW'(i);
    end else if (we) begin
      for (int j = 0; j < SLOTS; j++) begin
        if (wr_eff[j]) tbl[dst[j*AW +: AW]] <= new_tag[j*PW +: PW];
      end
    end
  end

  for (genvar r = 0; r < SLOTS*NSRC; r++) begin : g_rsrc
    assign rd_src[r*PW +: PW] = tbl[src[r*AW +: AW]];
  end
  for (genvar k = 0; k < SLOTS; k++) begin : g_rdst
    assign rd_dst[k*PW +: PW] = tbl[dst[k*AW +: AW]];
  end
endmodule

// File: rtl/rat_fwd.sv
// Resolves dependencies inside one rename group.
module rat_fwd #(
  parameter int SLOTS = 4,
  parameter int NSRC  = 2,
  parameter int AW    = 4,
  parameter int PW    = 6
) (
  input  logic [SLOTS-1:0]         wr_eff,
  input  logic [SLOTS*AW-1:0]      dst,
  input  logic [SLOTS*NSRC*AW-1:0] src,
  input  logic [SLOTS*PW-1:0]      new_tag,
  input  logic [SLOTS*NSRC*PW-1:0] rd_src,
  input  logic [SLOTS*PW-1:0]      rd_dst,
  output logic [SLOTS*NSRC*PW-1:0] src_tag,
  output logic [SLOTS*PW-1:0]      old_tag
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [PW-1:0] old_k;
    logic [NSRC*PW-1:0] src_k;

    // Later j overrides earlier j, so the nearest earlier writer wins.
    always_comb begin
      old_k = rd_dst[k*PW +: PW];
      src_k = rd_src[k*NSRC*PW +: NSRC*PW];
      for (int j = 0; j < k; j++) begin
        if (wr_eff[j]) begin
          if (dst[j*AW +: AW] == dst[k*AW +: AW]) old_k = new_tag[j*PW +: PW];
          for (int s = 0; s < NSRC; s++) begin
            if (dst[j*AW +: AW] == src[(k*NSRC+s)*AW +: AW])
              src_k[s*PW +: PW] = new_tag[j*PW +: PW];
          end
        end
      end
      if (!wr_eff[k]) old_k = '0;
    end

    assign old_tag[k*PW +: PW]              = old_k;
    assign src_tag[k*NSRC*PW +: NSRC*PW]    = src_k;
  end
endmodule

// File: rtl/rename_map4.sv
module rename_map4
  import rat_pkg::*;
#(
  parameter int SLOTS = RAT_SLOTS,
  parameter int AREGS = RAT_AREGS,
  parameter int PREGS = RAT_PREGS,
  parameter int NSRC  = RAT_NSRC,
  localparam int AW   = $clog2(AREGS),
  localparam int PW   = $clog2(PREGS),
  localparam int CW   = $clog2(SLOTS + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stall,
  input  logic [SLOTS-1:0]         in_vld,
  input  logic [SLOTS-1:0]         in_wr,
  input  logic [SLOTS*AW-1:0]      in_dst,
  input  logic [SLOTS*NSRC*AW-1:0] in_src,
  input  logic [SLOTS*PW-1:0]      free_tag,
  output logic [SLOTS-1:0]         out_vld,
  output logic [SLOTS-1:0]         out_wr,
  output logic [SLOTS*NSRC*PW-1:0] out_src_tag,
  output logic [SLOTS*PW-1:0]      out_new_tag,
  output logic [SLOTS*PW-1:0]      out_old_tag,
  output logic [CW-1:0]            out_alloc
);
  logic [SLOTS-1:0]         wr_eff;
  logic [SLOTS*PW-1:0]      new_tag;
  logic [CW-1:0]            cnt;
  logic [SLOTS*NSRC*PW-1:0] rd_src;
  logic [SLOTS*PW-1:0]      rd_dst;
  logic [SLOTS*NSRC*PW-1:0] src_tag;
  logic [SLOTS*PW-1:0]      old_tag;

  assign wr_eff = in_vld & in_wr;

  rat_alloc #(.SLOTS(SLOTS), .PW(PW)) u_alloc (
    .wr_eff   (wr_eff),
    .free_tag (free_tag),
    .new_tag  (new_tag),
    .cnt      (cnt)
  );

  rat_map #(.SLOTS(SLOTS), .NSRC(NSRC), .AREGS(AREGS), .PREGS(PREGS)) u_map (
    .clk     (clk),
    .rst     (rst),
    .we      (~stall),
    .wr_eff  (wr_eff),
    .dst     (in_dst),
    .new_tag (new_tag),
    .src     (in_src),
    .rd_src  (rd_src),
    .rd_dst  (rd_dst)
  );

  rat_fwd #(.SLOTS(SLOTS), .NSRC(NSRC), .AW(AW), .PW(PW)) u_fwd (
    .wr_eff  (wr_eff),
    .dst     (in_dst),
    .src     (in_src),
    .new_tag (new_tag),
    .rd_src  (rd_src),
    .rd_dst  (rd_dst),
    .src_tag (src_tag),
    .old_tag (old_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld     <= '0;
      out_wr      <= '0;
      out_alloc   <= '0;
      out_src_tag <= '0;
      out_new_tag <= '0;
      out_old_tag <= '0;
    end else if (stall) begin
      out_vld   <= '0;
      out_wr    <= '0;
      out_alloc <= '0;
    end else begin
      out_vld     <= in_vld;
      out_wr      <= wr_eff;
      out_alloc   <= cnt;
      out_src_tag <= src_tag;
      out_new_tag <= new_tag;
      out_old_tag <= old_tag;
    end
  end
endmodule

// File: rtl/rat_chk.sv
module rat_chk #(
  parameter int SLOTS = 4,
  parameter int AREGS = 16,
  parameter int PREGS = 64,
  parameter int NSRC  = 2,
  localparam int AW   = $clog2(AREGS),
  localparam int PW   = $clog2(PREGS),
  localparam int CW   = $clog2(SLOTS + 1)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     stall,
  input logic [SLOTS-1:0]         in_vld,
  input logic [SLOTS-1:0]         in_wr,
  input logic [SLOTS*AW-1:0]      in_dst,
  input logic [SLOTS*NSRC*AW-1:0] in_src,
  input logic [SLOTS*PW-1:0]      free_tag,
  input logic [SLOTS-1:0]         out_vld,
  input logic [SLOTS-1:0]         out_wr,
  input logic [SLOTS*NSRC*PW-1:0] out_src_tag,
  input logic [SLOTS*PW-1:0]      out_new_tag,
  input logic [SLOTS*PW-1:0]      out_old_tag,
  input logic [CW-1:0]            out_alloc
);
  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !stall |=> out_vld == $past(in_vld)); // R1

  AST_WR_WITHIN_VLD: assert property (@(posedge clk) disable iff (rst)
    (out_wr & ~out_vld) == '0); // R1

  AST_ALLOC_MATCHES_WR: assert property (@(posedge clk) disable iff (rst)
    out_alloc == CW'($countones(out_wr))); // R4

  AST_FIRST_WRITER_LANE0: assert property (@(posedge clk) disable iff (rst)
    (!stall && in_vld[0] && in_wr[0]) |=> out_new_tag[PW-1:0] == $past(free_tag[PW-1:0])); // R4

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    stall |=> (out_vld == '0 && out_alloc == '0)); // R9

  if (SLOTS > 1) begin : g_pair
    AST_SRC_FORWARD: assert property (@(posedge clk) disable iff (rst)
      (!stall && in_vld[0] && in_wr[0] && in_vld[1] &&
       in_src[NSRC*AW +: AW] == in_dst[AW-1:0])
      |=> out_src_tag[NSRC*PW +: PW] == out_new_tag[PW-1:0]); // R5

    AST_OLD_CHAIN: assert property (@(posedge clk) disable iff (rst)
      (!stall && in_vld[0] && in_wr[0] && in_vld[1] && in_wr[1] &&
       in_dst[AW +: AW] == in_dst[AW-1:0])
      |=> out_old_tag[PW +: PW] == out_new_tag[PW-1:0]); // R6
  end
endmodule

bind rename_map4 rat_chk #(.SLOTS(SLOTS), .AREGS(AREGS), .PREGS(PREGS), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .in_vld(in_vld), .in_wr(in_wr),
  .in_dst(in_dst), .in_src(in_src), .free_tag(free_tag), .out_vld(out_vld),
  .out_wr(out_wr), .out_src_tag(out_src_tag), .out_new_tag(out_new_tag),
  .out_old_tag(out_old_tag), .out_alloc(out_alloc)
);

// File: tb/rename_map4_tb.sv
`timescale 1ns/1ps
module rename_map4_tb;
  localparam int S  = 4;
  localparam int NS = 2;
  localparam int AW = 4;
  localparam int PW = 6;
  localparam int NA = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall = 1'b0;
  logic [S-1:0] in_vld = '0, in_wr = '0;
  logic [S*AW-1:0] in_dst = '0;
  logic [S*NS*AW-1:0] in_src = '0;
  logic [S*PW-1:0] free_tag = '0;
  logic [S-1:0] out_vld, out_wr;
  logic [S*NS*PW-1:0] out_src_tag;
  logic [S*PW-1:0] out_new_tag, out_old_tag;
  logic [2:0] out_alloc;

  always #2.5 clk = ~clk;

  rename_map4 u_dut (
    .clk(clk), .rst(rst), .stall(stall), .in_vld(in_vld), .in_wr(in_wr),
    .in_dst(in_dst), .in_src(in_src), .free_tag(free_tag), .out_vld(out_vld),
    .out_wr(out_wr), .out_src_tag(out_src_tag), .out_new_tag(out_new_tag),
    .out_old_tag(out_old_tag), .out_alloc(out_alloc)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int mdl [NA];
  int nf = 16;
  int g_dst [S];
  int g_src [S*NS];
  int unsigned rng = 32'h1234_5678;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned nxt();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  // Apply one group, check every output against the requirement model.
  task automatic apply(input logic [S-1:0] v, input logic [S-1:0] w, input string req);
    int e_src [S*NS];
    int e_new [S];
    int e_old [S];
    int n, t;
    @(negedge clk);
    in_vld = v; in_wr = w;
    for (int i = 0; i < S; i++) begin
      in_dst[i*AW +: AW] = AW'(g_dst[i]);
      free_tag[i*PW +: PW] = PW'((nf + i) % 64);
    end
    for (int i = 0; i < S*NS; i++) in_src[i*AW +: AW] = AW'(g_src[i]);
    n = 0;
    for (int k = 0; k < S; k++) begin
      e_new[k] = 0; e_old[k] = 0;
      for (int s = 0; s < NS; s++) begin
        t = mdl[g_src[k*NS+s]];
        for (int j = 0; j < k; j++)
          if (v[j] && w[j] && g_dst[j] == g_src[k*NS+s]) t = e_new[j];
        e_src[k*NS+s] = t;
      end
      if (v[k] && w[k]) begin
        e_new[k] = (nf + n) % 64; n++;
        t = mdl[g_dst[k]];
        for (int j = 0; j < k; j++)
          if (v[j] && w[j] && g_dst[j] == g_dst[k]) t = e_new[j];
        e_old[k] = t;
      end
    end
    @(posedge clk); #1;
    check({req, "/R1"}, "out_vld", int'(out_vld), int'(v));
    check({req, "/R1"}, "out_wr", int'(out_wr), int'(v & w));
    check({req, "/R4"}, "out_alloc", int'(out_alloc), n);
    for (int k = 0; k < S; k++) begin
      check({req, "/R4"}, $sformatf("new_tag[%0d]", k), int'(out_new_tag[k*PW +: PW]), e_new[k]);
      check({req, "/R6"}, $sformatf("old_tag[%0d]", k), int'(out_old_tag[k*PW +: PW]), e_old[k]);
      if (v[k])
        for (int s = 0; s < NS; s++)
          check({req, "/R3_R5"}, $sformatf("src_tag[%0d][%0d]", k, s),
                int'(out_src_tag[(k*NS+s)*PW +: PW]), e_src[k*NS+s]);
    end
    for (int k = 0; k < S; k++) if (v[k] && w[k]) mdl[g_dst[k]] = e_new[k];
    nf = (nf + n) % 64;
    in_vld = '0; in_wr = '0;
  endtask

  // Read every architectural register through sources (R10 / map visibility).
  task automatic read_all(input string req);
    for (int b = 0; b < NA; b += S*NS) begin
      for (int i = 0; i < S; i++) g_dst[i] = 0;
      for (int i = 0; i < S*NS; i++) g_src[i] = (b + i) % NA;
      apply(4'b1111, 4'b0000, req);
    end
  endtask

  task automatic t_reset();
    check("R2", "out_vld after reset", int'(out_vld), 0);
    check("R2", "out_alloc after reset", int'(out_alloc), 0);
    read_all("R2");
  endtask

  task automatic t_basic();
    g_dst = '{3, 7, 9, 12};
    g_src = '{3, 4, 3, 1, 7, 9, 12, 3};   // slot0 reads own dst r3: no self-forward
    apply(4'b1111, 4'b1111, "R5");
    read_all("R10");
  endtask

  task automatic t_same4();
    g_dst = '{5, 5, 5, 5};
    g_src = '{5, 0, 5, 5, 5, 2, 5, 5};
    apply(4'b1111, 4'b1111, "R7");
    g_dst = '{0, 0, 0, 0};
    g_src = '{5, 5, 5, 5, 5, 5, 5, 5};
    apply(4'b1111, 4'b0000, "R7");
  endtask

  task automatic t_sparse();
    g_dst = '{8, 2, 8, 2};
    g_src = '{8, 2, 8, 2, 8, 2, 8, 2};
    apply(4'b1011, 4'b1101, "R8");     // slot1 no dst, slot2 invalid
    apply(4'b0101, 4'b1111, "R8");
    apply(4'b0000, 4'b1111, "R8");
    read_all("R8");
  endtask

  task automatic t_stall();
    @(negedge clk);
    stall = 1'b1; in_vld = 4'b1111; in_wr = 4'b1111;
    for (int i = 0; i < S; i++) in_dst[i*AW +: AW] = AW'(i + 10);
    @(posedge clk); #1;
    check("R9", "out_vld stalled", int'(out_vld), 0);
    check("R9", "out_alloc stalled", int'(out_alloc), 0);
    @(negedge clk);
    stall = 1'b0; in_vld = '0; in_wr = '0;
    read_all("R9");
  endtask

  task automatic t_random();
    for (int it = 0; it < 300; it++) begin
      for (int i = 0; i < S; i++) g_dst[i] = int'(nxt() % 6);
      for (int i = 0; i < S*NS; i++) g_src[i] = int'(nxt() % 6);
      apply(4'(nxt()), 4'(nxt() | nxt()), "R5_R6_R7");
    end
    read_all("R10");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < NA; i++) mdl[i] = i;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_basic();
    t_same4();
    t_sparse();
    t_stall();
    t_random();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule